// File: doc/BRIEF.md
# Serial EEPROM SPI Slave Model

This block behaves as a 256-byte nonvolatile memory reached over SPI mode 0. It is meant as the far-end target when a master controller is under test. It is synchronous to a system clock. The select, serial clock and data inputs are sampled through two-flop synchronizers, and the block acts on the edges it detects in the sampled serial clock. Each select period starts with an 8-bit opcode.

A read opcode is followed by a start address. After that the slave streams bytes for as long as the select stays low, and the address advances modulo 256. A write takes three separate select periods:
- a select period that enables the programming voltage;
- a select period that carries the write opcode, an address and data bytes, which are latched inside one aligned group of bytes;
- a select period that disables the programming voltage, which commits the latch to the array.

After a commit the block stays busy for a set number of clock cycles. During that time every opcode is ignored.

Top module: `ee_spi_slave`

## Requirements
- R1: After reset all 256 bytes read as 0xFF, and MISO is 1 whenever the select input is high.
- R2: Opcode 0xA7 followed by an address byte streams stored bytes MSB first from that address. MISO changes after SCK falling edges and is valid at rising edges. The address increments modulo 256 for each byte while the select stays low.
- R3: Once the read address has been received, MOSI data has no effect on the streamed bytes or on the array.
- R4: Opcode 0xA2 followed by an address byte latches the following data bytes. The lane is the two low address bits, the lane advances by one per byte and wraps inside the aligned 4-byte group, and a later byte on the same lane replaces the earlier one.
- R5: Latched bytes reach the array only when opcode 0xA4 arrives in its own select period while the programming voltage is on, which needs an earlier 0xA6. An 0xA4 with the voltage off discards the latch, and the array stays unchanged.
- R6: A deselect ends the current command. Any opcode that follows another opcode in the same select period is ignored.
- R7: An opcode that is not recognised makes the slave ignore the rest of the select period, and MISO stays 1.
- R8: A commit starts a busy interval of PROG_CYCLES clocks. An opcode received during that interval is ignored, so a read returns 0xFF bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, held at 1 while deselected |

## Verification
The bench builds the block with 4-byte write groups and PROG_CYCLES set to 200. With that interval, a read opcode issued right after a commit lands inside the busy window, and a short wait is enough to see the committed data. A complete 256-byte dump after reset, and a second one with a start address that wraps after the write scenarios, compare every address against an arithmetic model. This covers the untouched bytes next to each write: partial groups, lane wrap, lane overwrite, writes with the voltage off, and opcodes sent in the wrong select period.

// File: rtl/ee_spi_slave_pkg.sv
package ee_spi_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ    = 8'hA7;
  localparam logic [BYTE_W-1:0] OP_WRITE   = 8'hA2;
  localparam logic [BYTE_W-1:0] OP_VPP_ON  = 8'hA6;
  localparam logic [BYTE_W-1:0] OP_VPP_OFF = 8'hA4;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_RD_ADDR,
    ST_RD_STREAM,
    ST_WR_ADDR,
    ST_WR_DATA,
    ST_SKIP
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;      // select inactive (synchronized)
    logic shiftIn;   // SCK rising edge: sample bitIn
    logic bitIn;     // synchronized MOSI
    logic shiftOut;  // SCK falling edge: present next MISO bit
    logic rdStart;   // read address byte complete
    logic rdNext;    // one streamed byte complete
    logic wrAddr;    // write address byte complete
    logic wrByte;    // one write data byte complete
    logic vppOn;
    logic vppOff;
  } ctrlStrobe_t;
endpackage

// File: rtl/ee_spi_slave_ctrl.sv
module ee_spi_slave_ctrl
  import ee_spi_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              progBusy,
  input  logic [BYTE_W-1:0] rxNext,
  output ctrlStrobe_t       strb
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [1:0] csSync, sckSync, mosiSync;
  logic       sckLast;
  logic       selected, sckRise, sckFall, byteDone;
  logic [BIT_W-1:0] bitCnt;
  ctrlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sckSync  <= 2'b00;
      mosiSync <= 2'b00;
      sckLast  <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sckSync  <= {sckSync[0], sck};
      mosiSync <= {mosiSync[0], mosi};
      sckLast  <= sckSync[1];
    end
  end

  assign selected = !csSync[1];
  assign sckRise  = selected && sckSync[1] && !sckLast;
  assign sckFall  = selected && !sckSync[1] && sckLast;
  assign byteDone = sckRise && (bitCnt == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_CMD;
      bitCnt <= '0;
    end else if (!selected) begin
      state  <= ST_CMD;
      bitCnt <= '0;
    end else begin
      if (sckRise) bitCnt <= bitCnt + BIT_W'(1);
      state <= nextState;
    end
  end

  always_comb begin
    strb          = '0;
    strb.idle     = !selected;
    strb.shiftIn  = sckRise;
    strb.bitIn    = mosiSync[1];
    strb.shiftOut = sckFall;
    nextState     = state;
    if (byteDone) begin
      case (state)
        ST_CMD: begin
          nextState = ST_SKIP;
          if (!progBusy) begin
            case (rxNext)
              OP_READ:    nextState = ST_RD_ADDR;
              OP_WRITE:   nextState = ST_WR_ADDR;
              OP_VPP_ON:  strb.vppOn  = 1'b1;
              OP_VPP_OFF: strb.vppOff = 1'b1;
              default:    nextState = ST_SKIP;
            endcase
          end
        end
        ST_RD_ADDR: begin
          strb.rdStart = 1'b1;
          nextState    = ST_RD_STREAM;
        end
        ST_RD_STREAM: strb.rdNext = 1'b1;
        ST_WR_ADDR: begin
          strb.wrAddr = 1'b1;
          nextState   = ST_WR_DATA;
        end
        ST_WR_DATA: strb.wrByte = 1'b1;
        default:    nextState = ST_SKIP;
      endcase
    end
  end

  AST_BUSY_NO_VPP: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |-> !(strb.vppOn || strb.vppOff)); // R8
  AST_DESELECT_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> (state == ST_CMD)); // R6
endmodule

// File: rtl/ee_spi_slave_dp.sv
module ee_spi_slave_dp
  import ee_spi_slave_pkg::*;
#(
  parameter int LANE_W      = 2,
  parameter int PROG_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  output logic [BYTE_W-1:0] rxNext,
  output logic              progBusy,
  output logic              txBit
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LANES   = 1 << LANE_W;
  localparam int GROUP_W = ADDR_W - LANE_W;
  localparam int BUSY_W  = $clog2(PROG_CYCLES + 1);

  logic [BYTE_W-1:0]  mem [DEPTH];
  logic [BYTE_W-1:0]  wrLatch [LANES];
  logic [LANES-1:0]   wrMask;
  logic [GROUP_W-1:0] wrGroup;
  logic [BYTE_W-1:0]  rxShift, txShift;
  logic [ADDR_W-1:0]  addr, rdAddr;
  logic               vppFlag, commit;
  logic [BUSY_W-1:0]  busyCnt;

  assign rxNext   = {rxShift[BYTE_W-2:0], strb.bitIn};
  assign commit   = strb.vppOff && vppFlag;
  assign progBusy = (busyCnt != '0);
  assign rdAddr   = strb.rdStart ? rxNext[ADDR_W-1:0] : addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      txBit   <= 1'b1;
    end else if (strb.idle) begin
      txShift <= '1;
      txBit   <= 1'b1;
    end else if (strb.rdStart || strb.rdNext) begin
      txShift <= mem[rdAddr];
    end else if (strb.shiftOut) begin
      txBit   <= txShift[BYTE_W-1];
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (strb.rdStart || strb.rdNext) addr <= rdAddr + ADDR_W'(1);
    else if (strb.wrAddr) addr <= rxNext[ADDR_W-1:0];
    else if (strb.wrByte)
      addr <= {addr[ADDR_W-1:LANE_W], addr[LANE_W-1:0] + LANE_W'(1)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrMask  <= '0;
      wrGroup <= '0;
      for (int l = 0; l < LANES; l++) wrLatch[l] <= '0;
    end else if (strb.wrAddr) begin
      wrMask  <= '0;
      wrGroup <= rxNext[ADDR_W-1:LANE_W];
    end else if (strb.wrByte) begin
      wrLatch[addr[LANE_W-1:0]] <= rxNext;
      wrMask[addr[LANE_W-1:0]]  <= 1'b1;
    end else if (strb.vppOff) begin
      wrMask <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vppFlag <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (strb.vppOn) vppFlag <= 1'b1;
      else if (strb.vppOff) vppFlag <= 1'b0;
      if (commit) busyCnt <= BUSY_W'(PROG_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
    end else if (commit) begin
      for (int l = 0; l < LANES; l++)
        if (wrMask[l]) mem[{wrGroup, LANE_W'(l)}] <= wrLatch[l];
    end
  end

  AST_RD_ADDR_INC: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdNext |=> (addr == $past(addr) + ADDR_W'(1))); // R2
  AST_WR_IN_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |=> (addr[ADDR_W-1:LANE_W] == $past(addr[ADDR_W-1:LANE_W]))); // R4
  AST_OFF_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.vppOff |=> (wrMask == '0 && !vppFlag)); // R5
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> progBusy); // R8
endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave
  import ee_spi_slave_pkg::*;
#(
  parameter int LANE_W      = 2,
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  ctrlStrobe_t       strb;
  logic [BYTE_W-1:0] rxNext;
  logic              progBusy, txBit;

  ee_spi_slave_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .progBusy(progBusy), .rxNext(rxNext), .strb(strb)
  );

  ee_spi_slave_dp #(.LANE_W(LANE_W), .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxNext(rxNext), .progBusy(progBusy), .txBit(txBit)
  );

  assign miso = csN ? 1'b1 : txBit;
endmodule

// File: tb/ee_spi_slave_tb.sv
module ee_spi_slave_tb;
  localparam int HALF = 6;
  localparam int PROG = 200;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  always #4 clk = ~clk;

  ee_spi_slave #(.LANE_W(2), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] got, input logic [7:0] want);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic selOn();
    csN = 1'b0;
    waitClk(4);
  endtask

  task automatic selOff();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(8);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      waitClk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic readCheck(input logic [7:0] start, input int n, input logic [7:0] fill, input string req);
    logic [7:0] rx;
    selOn();
    xfer(8'hA7, rx);
    xfer(start, rx);
    for (int k = 0; k < n; k++) begin
      logic [7:0] a;
      a = start + k[7:0];
      xfer(fill, rx);
      check(rx == model[a], req, rx, model[a]);
    end
    selOff();
  endtask

  task automatic oneCmd(input logic [7:0] op);
    logic [7:0] rx;
    selOn();
    xfer(op, rx);
    selOff();
  endtask

  task automatic writeSeq(input logic [7:0] start, input logic [7:0] d [6], input int n,
                          input bit withOn, input bit settle);
    logic [7:0] rx;
    logic [7:0] stage [4];
    bit         hit [4];
    for (int l = 0; l < 4; l++) hit[l] = 1'b0;
    if (withOn) oneCmd(8'hA6);
    selOn();
    xfer(8'hA2, rx);
    xfer(start, rx);
    for (int k = 0; k < n; k++) begin
      logic [1:0] ln;
      ln = start[1:0] + k[1:0];
      xfer(d[k], rx);
      stage[ln] = d[k];
      hit[ln] = 1'b1;
    end
    selOff();
    oneCmd(8'hA4);
    if (withOn)
      for (int l = 0; l < 4; l++)
        if (hit[l]) model[{start[7:2], l[1:0]}] = stage[l];
    if (settle) waitClk(PROG + 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got %h expected %h", 8'h00, 8'h01);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [6];
    logic [7:0] rx;
    for (int a = 0; a < 256; a++) model[a] = 8'hFF;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    check(miso == 1'b1, "R1 idle", {7'd0, miso}, 8'h01);
    // R1: erased after reset; the 257th byte wraps to address 0 (R2)
    readCheck(8'h00, 257, 8'h00, "R1");

    // R4/R8: partial group write, then a read inside the busy window
    d = '{8'hAA, 8'h55, 8'h33, 8'h00, 8'h00, 8'h00};
    writeSeq(8'h10, d, 3, 1'b1, 1'b0);
    selOn();
    xfer(8'hA7, rx);
    check(miso == 1'b1, "R8 busy", {7'd0, miso}, 8'h01);
    xfer(8'h10, rx);
    xfer(8'h00, rx);
    check(rx == 8'hFF, "R8 busy read", rx, 8'hFF);
    selOff();
    waitClk(PROG + 20);
    readCheck(8'h10, 4, 8'h00, "R8 after busy");

    // R4: lane wrap inside group
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00};
    writeSeq(8'h2E, d, 4, 1'b1, 1'b1);
    readCheck(8'h2C, 4, 8'h00, "R4 wrap");

    // R4: six bytes, lanes repeat and later bytes replace earlier ones
    d = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    writeSeq(8'h40, d, 6, 1'b1, 1'b1);
    readCheck(8'h3F, 6, 8'h00, "R4 overwrite");

    // R5: no programming voltage, so nothing is committed
    d = '{8'h12, 8'h34, 8'h00, 8'h00, 8'h00, 8'h00};
    writeSeq(8'h50, d, 2, 1'b0, 1'b1);
    readCheck(8'h50, 2, 8'h00, "R5 no vpp");

    // R6: write opcode in the same select as the on opcode is ignored
    selOn();
    xfer(8'hA6, rx);
    xfer(8'hA2, rx);
    xfer(8'h60, rx);
    xfer(8'h77, rx);
    selOff();
    oneCmd(8'hA4);
    waitClk(PROG + 20);
    readCheck(8'h60, 1, 8'h00, "R6");

    // R7: unrecognised opcode, rest of the select ignored
    selOn();
    xfer(8'h3C, rx);
    xfer(8'hA7, rx);
    check(rx == 8'hFF, "R7", rx, 8'hFF);
    xfer(8'h10, rx);
    check(rx == 8'hFF, "R7", rx, 8'hFF);
    xfer(8'h00, rx);
    check(rx == 8'hFF, "R7 data", rx, 8'hFF);
    selOff();

    // R3: full dump with opcode-like MOSI data, start wraps through 0xFF
    readCheck(8'h80, 256, 8'hA6, "R3");
    readCheck(8'hFE, 4, 8'hA2, "R2 wrap");
    readCheck(8'h11, 2, 8'h00, "R2");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule